// File: doc/BRIEF.md
# Watchdog Reset Pulse Generator

When the watchdog expires, this block produces the reset pulse that goes off-chip. One 32-bit configuration word controls it. The low field of that word gives the pulse duration, counted in ticks of a 1 MHz strobe. Two mode bits at the top of the word set the pulse polarity and whether the pad is driven push-pull or open-drain.

Software can read both mode bits back directly. It cannot set or clear them as plain bits. A mode bit changes only when the top byte of a write holds one of four guard codes. A write with any other top byte leaves both mode bits as they were, and it still loads the duration field. This lets software reprogram the duration without disturbing how the pad is driven.

An expiry trigger starts a pulse, and a trigger that arrives during a pulse starts the count again. The level output and its output-enable together model a tristate pad. A parameter sets the duration field to 8 or 20 bits.

Top module: `rst_pulse_gen`

## Requirements
- R1: After synchronous reset, the duration field reads 0xFF, the polarity is active-low, the drive is open-drain and no pulse is in progress. The pad therefore shows pulse_out=1 and pulse_oe=0.
- R2: cfg_rdata always presents the configuration word: bit 31 = 1 for active-high, bit 30 = 1 for push-pull, bits FW-1:0 hold the duration field and all other bits read 0. FW is 20 when WIDE_FIELD=1 and 8 otherwise.
- R3: A write whose bits 31:24 equal 0xA5 selects active-high. A write whose bits 31:24 equal 0x5A selects active-low.
- R4: A write whose bits 31:24 equal 0xA8 selects push-pull. A write whose bits 31:24 equal 0x8A selects open-drain.
- R5: A write whose top byte is none of those four codes leaves both mode bits unchanged. Every write, guarded or not, loads the duration field from bits FW-1:0.
- R6: Written bits above the duration field and below bit 24 are dropped and read back as 0.
- R7: A one-cycle expiry pulse makes the pulse active from the next clock. With a duration field of N, the pulse stays active until N+1 tick strobes have been seen after the trigger.
- R8: An expiry that arrives while a pulse is active reloads the duration, so the pulse then lasts N+1 further ticks.
- R9: During the pulse, pulse_out equals 1 when active-high is selected and 0 when active-low is selected. Outside the pulse it holds the opposite level.
- R10: In push-pull mode, pulse_oe is 1 at all times. In open-drain mode, pulse_oe is 1 only while the pulse is active.
- R11: A write to the duration field during a pulse does not change the length of that pulse. The new value applies from the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| tick_1us | input | 1 | One-cycle strobe, once per microsecond |
| expire | input | 1 | Watchdog expiry trigger |
| pulse_out | output | 1 | Pad level |
| pulse_oe | output | 1 | Pad output-enable |

## Verification
A wrong mode bit shows up at once: cfg_rdata reflects it in the cycle after the write, and pulse_out or pulse_oe shows the wrong level or enable on the next cycle. A wrong duration count is hidden until the pulse ends, so it appears only as a pulse that ends one or more ticks early or late. For that reason the bench measures complete pulses, including pulses that are restarted or written to partway through. A behavioural model is compared against every output on every cycle, while random writes, guard codes and triggers are applied.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    localparam logic [7:0] GUARD_POL_HIGH = 8'hA5;
    localparam logic [7:0] GUARD_POL_LOW  = 8'h5A;
    localparam logic [7:0] GUARD_DRV_PP   = 8'hA8;
    localparam logic [7:0] GUARD_DRV_OD   = 8'h8A;

    localparam int FIELD_NARROW = 8;
    localparam int FIELD_WIDE   = 20;
    localparam int DEFAULT_DUR  = 255;

    typedef enum logic [1:0] {POL_KEEP, POL_TO_HIGH, POL_TO_LOW} pol_cmd_e;
    typedef enum logic [1:0] {DRV_KEEP, DRV_TO_PP, DRV_TO_OD} drv_cmd_e;

    typedef struct packed {
        logic active_high;
        logic push_pull;
    } pad_mode_t;

    function automatic pol_cmd_e decode_pol(input logic [7:0] top);
        case (top)
            GUARD_POL_HIGH: return POL_TO_HIGH;
            GUARD_POL_LOW:  return POL_TO_LOW;
            default:        return POL_KEEP;
        endcase
    endfunction

    function automatic drv_cmd_e decode_drv(input logic [7:0] top);
        case (top)
            GUARD_DRV_PP: return DRV_TO_PP;
            GUARD_DRV_OD: return DRV_TO_OD;
            default:      return DRV_KEEP;
        endcase
    endfunction

endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
    import rpg_pkg::*;
#(
    parameter int FW = FIELD_WIDE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [31:0]     wr_data,
    output logic [FW-1:0]   dur_q,
    output pad_mode_t       mode_q
);
    localparam logic [FW-1:0] DUR_RESET = FW'(DEFAULT_DUR);

    pol_cmd_e pol_cmd;
    drv_cmd_e drv_cmd;
    logic     unused_mid_bits;

    assign pol_cmd         = decode_pol(wr_data[31:24]);
    assign drv_cmd         = decode_drv(wr_data[31:24]);
    assign unused_mid_bits = ^wr_data[23:FW];

    always_ff @(posedge clk) begin
        if (rst) begin
            dur_q              <= DUR_RESET;
            mode_q.active_high <= 1'b0;
            mode_q.push_pull   <= 1'b0;
        end else if (wr_en) begin
            dur_q <= wr_data[FW-1:0];
            if (pol_cmd == POL_TO_HIGH) mode_q.active_high <= 1'b1;
            else if (pol_cmd == POL_TO_LOW) mode_q.active_high <= 1'b0;
            if (drv_cmd == DRV_TO_PP) mode_q.push_pull <= 1'b1;
            else if (drv_cmd == DRV_TO_OD) mode_q.push_pull <= 1'b0;
        end
    end

    a_r3_guard_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:24] == 8'hA5) |=> mode_q.active_high);
    a_r3_guard_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:24] == 8'h5A) |=> !mode_q.active_high);
    a_r4_guard_od: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:24] == 8'h8A) |=> !mode_q.push_pull);
    a_r5_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:24] != 8'hA5 && wr_data[31:24] != 8'h5A &&
         wr_data[31:24] != 8'hA8 && wr_data[31:24] != 8'h8A) |=> $stable(mode_q));
    a_r5_dur_loaded: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> dur_q == $past(wr_data[FW-1:0]));

endmodule

// File: rtl/rpg_pulse_timer.sv
module rpg_pulse_timer
    import rpg_pkg::*;
#(
    parameter int FW = FIELD_WIDE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          trigger,
    input  logic [FW-1:0] dur,
    output logic          active
);
    logic [FW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            left_q <= '0;
        end else if (trigger) begin
            active <= 1'b1;
            left_q <= dur;
        end else if (active && tick) begin
            if (left_q == '0) active <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    a_r7_start: assert property (@(posedge clk) disable iff (rst)
        trigger |=> active && left_q == $past(dur));
    a_r7_finish: assert property (@(posedge clk) disable iff (rst)
        (active && !trigger && tick && left_q == '0) |=> !active);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (active && !trigger && !tick) |=> active && $stable(left_q));

endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
    import rpg_pkg::*;
#(
    parameter bit WIDE_FIELD = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        tick_1us,
    input  logic        expire,
    output logic        pulse_out,
    output logic        pulse_oe
);
    localparam int FW = WIDE_FIELD ? FIELD_WIDE : FIELD_NARROW;
    localparam int PAD_ZEROS = 30 - FW;

    logic [FW-1:0] dur;
    pad_mode_t     mode;
    logic          active;

    rpg_cfg_reg #(.FW(FW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .dur_q   (dur),
        .mode_q  (mode)
    );

    rpg_pulse_timer #(.FW(FW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1us),
        .trigger (expire),
        .dur     (dur),
        .active  (active)
    );

    assign cfg_rdata = {mode.active_high, mode.push_pull, {PAD_ZEROS{1'b0}}, dur};
    assign pulse_out = active ? mode.active_high : ~mode.active_high;
    assign pulse_oe  = mode.push_pull | active;

    a_r10_od_float: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[30] && !active) |-> !pulse_oe);
    a_r9_level: assert property (@(posedge clk) disable iff (rst)
        active |-> pulse_out == cfg_rdata[31]);

endmodule

// File: tb/tb_rst_pulse_gen.sv
module tb_rst_pulse_gen;
    localparam int FW = 20;
    localparam int MASK = (1 << FW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick_1us = 1'b0;
    logic        expire = 1'b0;
    logic        pulse_out, pulse_oe;

    int checks = 0;
    int failures = 0;
    int tdiv = 1;
    int tphase = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference
    int m_dur = 255;
    bit m_ah = 0, m_pp = 0;
    int m_left = 0;

    always #10 clk = ~clk;

    rst_pulse_gen #(.WIDE_FIELD(1'b1)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tick_1us(tick_1us), .expire(expire),
        .pulse_out(pulse_out), .pulse_oe(pulse_oe)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_dur = 255; m_ah = 0; m_pp = 0; m_left = 0;
        end else begin
            if (expire) m_left = m_dur + 1;
            else if (tick_1us && m_left > 0) m_left = m_left - 1;
            if (cfg_we) begin
                m_dur = int'(cfg_wdata) & MASK;
                case (cfg_wdata[31:24])
                    8'hA5: m_ah = 1;
                    8'h5A: m_ah = 0;
                    8'hA8: m_pp = 1;
                    8'h8A: m_pp = 0;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model: R2 R7 R9 R10
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] e_rd;
            bit on;
            on = m_left > 0;
            e_rd = {m_ah, m_pp, 10'b0, 20'(m_dur)};
            check(cfg_rdata == e_rd, "R2 readback", cfg_rdata, e_rd);
            check(pulse_out == (on ? m_ah : !m_ah), "R9 level", pulse_out, on ? m_ah : !m_ah);
            check(pulse_oe == (m_pp | on), "R10 enable", pulse_oe, m_pp | on);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        tick_1us = (tphase == 0);
        tphase = (tphase + 1 >= tdiv) ? 0 : tphase + 1;
        cfg_we = 1'b0;
        expire = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        step();
        cfg_we = 1'b1;
        cfg_wdata = d;
        step();
    endtask

    // measure active cycles of a pulse; retrig_at/wr_at < 0 disables
    task automatic pulse_len(input bit ah, input int retrig_at, input int wr_at,
                             output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (i > 0 && pulse_out == ah) n++;
            if (i == 0 || i == retrig_at) expire = 1'b1;
            if (i == wr_at) begin cfg_we = 1'b1; cfg_wdata = 32'h0000_0050; end
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cfg_rdata == 32'h0000_00FF, "R1 reset word", cfg_rdata, 32'hFF);
        check(pulse_out == 1'b1 && pulse_oe == 1'b0, "R1 idle pad", {pulse_out, pulse_oe}, 2'b10);

        tdiv = 1;
        wr(32'h0000_0003);
        check(cfg_rdata == 32'h3, "R5 unguarded write loads duration", cfg_rdata, 3);
        pulse_len(1'b0, -1, -1, n);
        check(n == 4, "R7 duration N+1", n, 4);

        wr(32'hA500_0003);
        check(cfg_rdata[31] == 1'b1, "R3 active-high", cfg_rdata[31], 1);
        pulse_len(1'b1, -1, -1, n);
        check(n == 4, "R9 active-high pulse", n, 4);

        wr(32'hA800_0003);
        check(cfg_rdata[30] == 1'b1 && pulse_oe == 1'b1, "R4 push-pull", cfg_rdata[31:30], 2'b11);
        wr(32'h8A00_0003);
        check(cfg_rdata[30] == 1'b0, "R4 open-drain", cfg_rdata[30], 0);
        wr(32'h5A00_0003);
        check(cfg_rdata[31] == 1'b0, "R3 active-low", cfg_rdata[31], 0);

        wr(32'h12FF_FFFF);
        check(cfg_rdata == 32'h000F_FFFF, "R5 R6 ignored top and middle bits", cfg_rdata, 32'hFFFFF);
        wr(32'hA8FF_FFFF);
        check(cfg_rdata == 32'h400F_FFFF, "R6 guarded write drops middle bits", cfg_rdata, 32'h400FFFFF);
        wr(32'h8A00_0005);

        pulse_len(1'b0, 3, -1, n);
        check(n == 9, "R8 retrigger restarts count", n, 9);

        wr(32'h0000_0004);
        pulse_len(1'b0, -1, 2, n);
        check(n == 5, "R11 mid-pulse write keeps length", n, 5);
        check(cfg_rdata == 32'h50, "R11 new duration stored", cfg_rdata, 32'h50);

        tdiv = 3;
        wr(32'h0000_0002);
        pulse_len(1'b0, -1, -1, n);
        check(n >= 7 && n <= 9, "R7 slow ticks", n, 8);

        for (int k = 0; k < 4000; k++) begin
            step();
            if ($urandom_range(0, 9) == 0) begin
                logic [7:0] top;
                case ($urandom_range(0, 5))
                    0: top = 8'hA5; 1: top = 8'h5A; 2: top = 8'hA8; 3: top = 8'h8A;
                    default: top = 8'($urandom);
                endcase
                cfg_we = 1'b1;
                cfg_wdata = {top, 24'($urandom_range(0, 12))};
            end
            if ($urandom_range(0, 29) == 0) expire = 1'b1;
        end

        repeat (60) step();
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule